// File: doc/BRIEF.md
# Two-Packet Bus Request Encoder

This block issues the request phase of a transaction on a shared processor bus. The core hands it one request at a time over a ready/valid handshake. A request carries a 36-bit physical address, a transaction kind (memory read, memory write, I/O read or I/O write), a caching attribute, a length code and a byte-enable mask. The encoder stores the request and waits for the bus-grant input. It then time-shares one narrow set of request pins over two consecutive bus clocks. The first packet carries the 8-byte-aligned address together with the kind. The second packet carries the attribute, the length and the byte enables.

The length and byte enables that go out depend on the caching attribute. A write-back memory access always moves a whole 64-byte line, so the encoder forces the full-line length code and all byte enables on. Every other memory type, and every I/O access, goes out exactly as the core asked. An I/O request drives a port number on the address pins, and the encoder always marks it as uncacheable. The encoder rejects two kinds of request and raises a one-cycle error flag for each: a write-back line request whose address is not line aligned, and a memory request that names an attribute code outside the five defined types. A rejected request never reaches the bus. Arbitration, snoop, response and data phases belong to other blocks.

Top module: `breq_encoder`

## Requirements
- R1: While reset is held, and after it is released, `req_ready` is 1 and `pkt_valid`, `pkt_is_b`, `req_err` and all of `bus_pins` are 0.
- R2: The encoder accepts a request in a cycle where `req_valid` and `req_ready` are both 1. After it accepts a good request, `req_ready` stays 0 until the cycle after packet B, and then returns to 1.
- R3: No packet is driven while the request waits for grant. Packet A appears in the cycle after the first rising clock edge at which `bus_grant` is sampled high.
- R4: Packet A has `pkt_valid`=1 and `pkt_is_b`=0. Its `bus_pins[32:0]` carry address bits 35..3 and `bus_pins[34:33]` carry the kind. Address bits 2..0 never appear on the pins.
- R5: Packet B follows packet A in the very next cycle, with `pkt_valid`=1 and `pkt_is_b`=1. Its `bus_pins[12:10]` carry the attribute, `bus_pins[9:8]` the length code and `bus_pins[7:0]` the byte enables. Bits 34..13 are 0.
- R6: The kind codes are 0 memory read, 1 memory write, 2 I/O read and 3 I/O write. The attribute codes are 0 uncacheable, 1 write-combining, 2 write-through, 3 write-protected and 4 write-back. A memory request with attribute 4 is issued with length code 2'b11 and byte enables 8'hFF, whatever was requested.
- R7: A write-back memory request with nonzero address bits 5..0 is rejected. `req_err` is 1 for exactly the one cycle after acceptance, no packet is driven, and `req_ready` stays 1.
- R8: A memory request with attribute 0 to 3 is issued with its requested length code and byte-enable mask unchanged, including partial byte or word masks.
- R9: An I/O request is issued with attribute 0 and its requested length and byte enables. The requested attribute, even an undefined one, is ignored.
- R10: A memory request with an attribute code of 5, 6 or 7 is rejected in the same way as R7, so packet B never carries an attribute above 4.
- R11: In every cycle where `pkt_valid` is 0, `bus_pins` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Encoder can accept a request |
| req_addr | input | 36 | Physical address or I/O port |
| req_kind | input | 2 | 0 mem read, 1 mem write, 2 I/O read, 3 I/O write |
| req_attr | input | 3 | Caching attribute, codes 0..4 defined |
| req_len | input | 2 | Length code |
| req_be | input | 8 | Byte-enable mask |
| bus_grant | input | 1 | Bus ownership granted by the arbiter |
| req_err | output | 1 | One-cycle pulse: the last accepted request was rejected |
| pkt_valid | output | 1 | A request packet is on the pins |
| pkt_is_b | output | 1 | 0 for packet A, 1 for packet B |
| bus_pins | output | 35 | Shared request pins |

## Verification
A corrupted sequencer state shows up at the ports within one or two cycles. It appears as a packet A with no packet B after it, a packet driven before grant, or `req_ready` rising while the pins are still busy. The checker flags each of these on the cycle it happens. A wrong captured field or a wrong cacheability decision appears only in the packet contents. The bench compares each packet word against a value it computes from the request, in the exact cycle the packet is due. Rejections are checked through `req_err`, the absence of packets and the immediate return of `req_ready`.

// File: rtl/breq_pkg.sv
package breq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PKT_A = 2'd2,
    ST_PKT_B = 2'd3
  } breq_state_e;

  localparam int KIND_W     = 2;
  localparam int ATTR_W     = 3;
  localparam int LEN_W      = 2;
  localparam int ATTR_TYPES = 5;

  localparam logic [ATTR_W-1:0] ATTR_UNCACHED  = 3'd0;
  localparam logic [ATTR_W-1:0] ATTR_WRBACK    = 3'd4;
  localparam logic [LEN_W-1:0]  LEN_FULL_LINE  = 2'b11;

  // kind bit 1 set selects port space
  function automatic logic kind_is_io(input logic [KIND_W-1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/breq_classify.sv
module breq_classify
  import breq_pkg::*;
#(
  parameter int PA_W   = 36,
  parameter int LINE_B = 6,
  parameter int BE_W   = 8
) (
  input  logic [PA_W-1:0]   addr_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              reject_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [BE_W-1:0]   be_o
);

  logic is_io;
  logic attr_known;
  logic line_xfer;
  logic off_line;

  always_comb begin
    is_io      = kind_is_io(kind_i);
    attr_known = (int'(attr_i) < ATTR_TYPES);
    line_xfer  = !is_io && (attr_i == ATTR_WRBACK);
    off_line   = line_xfer && (addr_i[LINE_B-1:0] != '0);
    reject_o   = (!is_io && !attr_known) || off_line;
    attr_o     = is_io ? ATTR_UNCACHED : attr_i;
    len_o      = line_xfer ? LEN_FULL_LINE : len_i;
    be_o       = line_xfer ? {BE_W{1'b1}} : be_i;
  end

endmodule

// File: rtl/breq_seq.sv
module breq_seq
  import breq_pkg::*;
(
  input  logic        clk,
  input  logic        arst_n,
  input  logic        take_ok,
  input  logic        take_bad,
  input  logic        grant,
  output breq_state_e state_o,
  output logic        err_o
);

  breq_state_e state_q, state_d;
  logic        err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_ok) state_d = ST_WAIT;
      ST_WAIT:  if (grant)   state_d = ST_PKT_A;
      ST_PKT_A:              state_d = ST_PKT_B;
      ST_PKT_B:              state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= take_bad;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

endmodule

// File: rtl/breq_pack.sv
module breq_pack
  import breq_pkg::*;
#(
  parameter int ADDR_PINS = 33,
  parameter int BE_W      = 8,
  parameter int PIN_W     = 35
) (
  input  breq_state_e          state_i,
  input  logic [ADDR_PINS-1:0] addr_hi_i,
  input  logic [KIND_W-1:0]    kind_i,
  input  logic [ATTR_W-1:0]    attr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [BE_W-1:0]      be_i,
  output logic [PIN_W-1:0]     pins_o,
  output logic                 valid_o,
  output logic                 is_b_o
);

  localparam int B_W = ATTR_W + LEN_W + BE_W;

  logic [PIN_W-1:0] word_a;
  logic [PIN_W-1:0] word_b;

  assign word_a = {kind_i, addr_hi_i};

  generate
    if (PIN_W > B_W) begin : g_pad
      assign word_b = {{(PIN_W-B_W){1'b0}}, attr_i, len_i, be_i};
    end else begin : g_nopad
      assign word_b = {attr_i, len_i, be_i};
    end
  endgenerate

  always_comb begin
    pins_o  = '0;
    valid_o = 1'b0;
    is_b_o  = 1'b0;
    if (state_i == ST_PKT_A) begin
      pins_o  = word_a;
      valid_o = 1'b1;
    end else if (state_i == ST_PKT_B) begin
      pins_o  = word_b;
      valid_o = 1'b1;
      is_b_o  = 1'b1;
    end
  end

endmodule

// File: rtl/breq_encoder.sv
module breq_encoder
  import breq_pkg::*;
#(
  parameter int PA_W   = 36,
  parameter int ALIGN_B = 3,
  parameter int LINE_B = 6,
  localparam int BE_W      = 1 << ALIGN_B,
  localparam int ADDR_PINS = PA_W - ALIGN_B,
  localparam int PIN_W     = ADDR_PINS + KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_attr,
  input  logic [1:0]        req_len,
  input  logic [BE_W-1:0]   req_be,
  input  logic              bus_grant,
  output logic              req_err,
  output logic              pkt_valid,
  output logic              pkt_is_b,
  output logic [PIN_W-1:0]  bus_pins
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  breq_state_e state;
  logic        take;
  logic        reject;
  logic [ATTR_W-1:0] attr_eff;
  logic [LEN_W-1:0]  len_eff;
  logic [BE_W-1:0]   be_eff;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;

  breq_classify #(.PA_W(PA_W), .LINE_B(LINE_B), .BE_W(BE_W)) u_classify (
    .addr_i   (req_addr),
    .kind_i   (req_kind),
    .attr_i   (req_attr),
    .len_i    (req_len),
    .be_i     (req_be),
    .reject_o (reject),
    .attr_o   (attr_eff),
    .len_o    (len_eff),
    .be_o     (be_eff)
  );

  breq_seq u_seq (
    .clk      (clk),
    .arst_n   (arst_n),
    .take_ok  (take && !reject),
    .take_bad (take && reject),
    .grant    (bus_grant),
    .state_o  (state),
    .err_o    (req_err)
  );

  // captured request, loaded only on a good acceptance
  logic                 cap_en;
  logic [ADDR_PINS-1:0] cap_addr_q;
  logic [KIND_W-1:0]    cap_kind_q;
  logic [ATTR_W-1:0]    cap_attr_q;
  logic [LEN_W-1:0]     cap_len_q;
  logic [BE_W-1:0]      cap_be_q;

  assign cap_en = take && !reject;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      cap_addr_q <= req_addr[PA_W-1:ALIGN_B];
      cap_kind_q <= req_kind;
      cap_attr_q <= attr_eff;
      cap_len_q  <= len_eff;
      cap_be_q   <= be_eff;
    end
  end

  breq_pack #(.ADDR_PINS(ADDR_PINS), .BE_W(BE_W), .PIN_W(PIN_W)) u_pack (
    .state_i   (state),
    .addr_hi_i (cap_addr_q),
    .kind_i    (cap_kind_q),
    .attr_i    (cap_attr_q),
    .len_i     (cap_len_q),
    .be_i      (cap_be_q),
    .pins_o    (bus_pins),
    .valid_o   (pkt_valid),
    .is_b_o    (pkt_is_b)
  );

endmodule

// File: rtl/breq_encoder_chk.sv
module breq_encoder_chk #(
  parameter int PIN_W = 35
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_err,
  input logic             bus_grant,
  input logic             pkt_valid,
  input logic             pkt_is_b,
  input logic [PIN_W-1:0] bus_pins
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !req_ready); // R2

  AST_A_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_is_b) |-> $past(bus_grant)); // R3

  AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_is_b) |=> (pkt_valid && pkt_is_b)); // R5

  AST_SINGLE_B: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_is_b |=> !pkt_is_b); // R5

  AST_WB_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_is_b && bus_pins[12:10] == 3'd4) |-> (bus_pins[9:0] == 10'h3FF)); // R6

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!pkt_valid && req_ready)); // R7

  AST_ATTR_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_is_b |-> (bus_pins[12:10] <= 3'd4)); // R10

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (bus_pins == '0)); // R11

endmodule

bind breq_encoder breq_encoder_chk #(.PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_err   (req_err),
  .bus_grant (bus_grant),
  .pkt_valid (pkt_valid),
  .pkt_is_b  (pkt_is_b),
  .bus_pins  (bus_pins)
);

// File: tb/sim_breq_encoder.sv
`timescale 1ns/1ps
module sim_breq_encoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [35:0] req_addr;
  logic [1:0]  req_kind;
  logic [2:0]  req_attr;
  logic [1:0]  req_len;
  logic [7:0]  req_be;
  logic        bus_grant;
  logic        req_err;
  logic        pkt_valid;
  logic        pkt_is_b;
  logic [34:0] bus_pins;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  breq_encoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_attr(req_attr),
    .req_len(req_len), .req_be(req_be), .bus_grant(bus_grant),
    .req_err(req_err), .pkt_valid(pkt_valid), .pkt_is_b(pkt_is_b),
    .bus_pins(bus_pins)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_reject(input logic [1:0] k, input logic [2:0] a,
                                      input logic [35:0] ad);
    if (k[1]) return 1'b0;
    if (a > 3'd4) return 1'b1;
    return (a == 3'd4) && (ad[5:0] != 6'd0);
  endfunction

  function automatic logic [34:0] exp_a(input logic [1:0] k, input logic [35:0] ad);
    return {k, ad[35:3]};
  endfunction

  function automatic logic [34:0] exp_b(input logic [1:0] k, input logic [2:0] a,
                                        input logic [1:0] l, input logic [7:0] b);
    logic [2:0] ea;
    logic [1:0] el;
    logic [7:0] eb;
    ea = k[1] ? 3'd0 : a;
    el = (!k[1] && a == 3'd4) ? 2'b11 : l;
    eb = (!k[1] && a == 3'd4) ? 8'hFF : b;
    return {22'd0, ea, el, eb};
  endfunction

  task automatic run_req(input logic [35:0] ad, input logic [1:0] k, input logic [2:0] a,
                         input logic [1:0] l, input logic [7:0] b, input int gap,
                         input string tag);
    logic bad;
    bad = exp_reject(k, a, ad);
    @(negedge clk);
    check({tag, " R2 ready idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = ad; req_kind = k; req_attr = a; req_len = l; req_be = b;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = '1; req_attr = 3'd7; req_len = 2'd0; req_be = 8'h00;
    if (bad) begin
      check({tag, " R7/R10 err pulse"}, 64'(req_err), 64'd1);
      check({tag, " R7/R10 no packet"}, 64'(pkt_valid), 64'd0);
      check({tag, " R7/R10 ready stays"}, 64'(req_ready), 64'd1);
      @(negedge clk);
      check({tag, " R7 err one cycle"}, 64'(req_err), 64'd0);
      check({tag, " R11 pins quiet"}, 64'(bus_pins), 64'd0);
    end else begin
      check({tag, " R2 ready low"}, 64'(req_ready), 64'd0);
      check({tag, " R2 no err"}, 64'(req_err), 64'd0);
      for (int i = 0; i < gap; i++) begin
        check({tag, " R3 wait no packet"}, 64'(pkt_valid), 64'd0);
        check({tag, " R11 pins quiet"}, 64'(bus_pins), 64'd0);
        @(negedge clk);
      end
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      check({tag, " R3/R4 packet A"}, {pkt_valid, pkt_is_b}, 2'b10);
      check({tag, " R4 A word"}, 64'(bus_pins), 64'(exp_a(k, ad)));
      check({tag, " R2 ready low A"}, 64'(req_ready), 64'd0);
      @(negedge clk);
      check({tag, " R5 packet B"}, {pkt_valid, pkt_is_b}, 2'b11);
      check({tag, " R5/R6/R8/R9 B word"}, 64'(bus_pins), 64'(exp_b(k, a, l, b)));
      @(negedge clk);
      check({tag, " R2 ready back"}, 64'(req_ready), 64'd1);
      check({tag, " R11 pins idle"}, {pkt_valid, bus_pins}, 36'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_attr = '0;
    req_len = '0; req_be = '0; bus_grant = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset outputs", {req_err, pkt_valid, pkt_is_b, bus_pins}, 38'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {req_ready, req_err, pkt_valid, bus_pins}, {1'b1, 37'd0});

    // directed corners
    run_req(36'h8_0001_0A40, 2'd0, 3'd4, 2'b00, 8'h01, 0, "R6 wb aligned read");
    run_req(36'h8_0001_0A48, 2'd1, 3'd4, 2'b11, 8'hFF, 1, "R7 wb misaligned");
    run_req(36'h0_0000_0CF8, 2'd3, 3'd7, 2'b00, 8'h0F, 2, "R9 io undefined attr");
    run_req(36'h1_2345_6780, 2'd1, 3'd6, 2'b00, 8'h01, 0, "R10 mem attr 6");
    run_req(36'hF_FFFF_FFFF, 2'd1, 3'd0, 2'b00, 8'h30, 3, "R8 uc word write");
    run_req(36'hF_FFFF_FFC0, 2'd1, 3'd4, 2'b01, 8'h00, 0, "R6 wb top line");
    run_req(36'h0_0000_0007, 2'd0, 3'd1, 2'b01, 8'h80, 1, "R4 low bits hidden");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [35:0] ad;
      ad = {4'($urandom), 32'($urandom)};
      if ($urandom % 2) ad[5:0] = 6'd0;
      run_req(ad, 2'($urandom), 3'($urandom % 7), 2'($urandom), 8'($urandom),
              int'($urandom % 4), "R5 random");
    end

    // grant while idle must not start anything
    bus_grant = 1'b1;
    repeat (3) @(negedge clk);
    bus_grant = 1'b0;
    check("R3 grant idle no packet", {pkt_valid, bus_pins}, 36'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule